// File: doc/BRIEF.md
# Trimmed Real-Time Clock with Alarm

This block keeps wall time in whole seconds for a chip that spends long stretches asleep. It runs from a 32.768 kHz crystal clock. A prescaler turns that clock into one tick per second, and the tick advances a seconds counter. Software may overwrite the counter at any time. Each overwrite restarts the prescaler, so the next tick comes one full second later.

Crystals drift, so a signed trim value corrects the prescaler. Seconds are grouped into calibration windows of a fixed length. The last second of each window is made shorter or longer by the trim amount, counted in crystal cycles. Over a long run the average rate can be pulled to within one cycle per window.

A comparator watches the counter against a programmed alarm time. When counting lands on that time and the alarm is enabled, a sticky wake flag is set. The flag is the signal that brings the rest of the system out of sleep, and it stays set until software clears it.

Top module: `rtc_trim`

## Requirements
- R1: While reset is asserted, `sec_cnt` is 0, `sec_tick` is 0 and `wake` is 0.
- R2: A `sec_load` pulse puts `sec_load_val` on `sec_cnt` after the next rising edge, with `sec_tick` low. It also restarts both the prescaler and the calibration window. The first tick then comes exactly DIV_CYCLES edges after the load edge.
- R3: With no load, `sec_tick` is high for exactly one cycle per second, and `sec_cnt` shows the old value plus one in that same cycle. An untrimmed second lasts DIV_CYCLES cycles (32768 by default).
- R4: `trim_val` is a signed two's-complement count. Seconds are numbered from the last load or reset. Every CAL_SECONDS-th second (the last of each window) lasts DIV_CYCLES minus `trim_val` cycles, so a positive trim shortens it and a negative trim lengthens it.
- R5: `sec_cnt` wraps from all ones to zero on the next tick.
- R6: When a tick brings `sec_cnt` equal to `alarm_val` and `alarm_en` is 1, `wake` rises one cycle after that tick.
- R7: Once set, `wake` stays 1 across later ticks. It falls on the edge that samples a `wake_clr` pulse.
- R8: With `alarm_en` at 0, reaching `alarm_val` leaves `wake` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_load | input | 1 | Write strobe for the seconds counter |
| sec_load_val | input | CNT_W | Value written on `sec_load` |
| trim_val | input | TRIM_W | Signed drift correction in cycles per window |
| alarm_val | input | CNT_W | Alarm time in seconds |
| alarm_en | input | 1 | Allows a match to set `wake` |
| wake_clr | input | 1 | Clears the wake flag (write-one-to-clear pulse) |
| sec_cnt | output | CNT_W | Current seconds value |
| sec_tick | output | 1 | One-cycle pulse on each increment |
| wake | output | 1 | Sticky alarm wake request |

## Verification
The counter value and the tick appear together, on the edge that ends a second. The wake flag follows one edge later, and a load or a clear shows on the edge that samples it. The monitor compares each tick against a queued expectation at the falling edge, and it measures the gap in edges since the previous tick or load. That gap must match the expected length of the second. Each alarm check reads the flag twice: once on the tick's falling edge, where it must still be 0, and once on the falling edge after it.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
   // Length in cycles of a calibrated second: a positive trim removes cycles.
   function automatic int rtc_period(input int nominal, input int trim);
      return nominal - trim;
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int DIV_CYCLES  = 32768,
   parameter int TRIM_W      = 8,
   parameter int CAL_SECONDS = 60,
   parameter bit TRIM_EN     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic signed [TRIM_W-1:0] trim,
   output logic                     step
);
   localparam int TRIM_MAX = 2 ** (TRIM_W - 1);
   localparam int DIV_W    = $clog2(DIV_CYCLES + TRIM_MAX + 1);
   localparam int CAL_W    = $clog2(CAL_SECONDS);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] last_c;
   logic [CAL_W-1:0] cal_q;
   logic             cal_end;

   assign cal_end = (cal_q == CAL_W'(CAL_SECONDS - 1));

   generate
      if (TRIM_EN) begin : g_trim
         always_comb begin
            if (cal_end) last_c = DIV_W'(rtc_period(DIV_CYCLES, int'(trim)) - 1);
            else         last_c = DIV_W'(DIV_CYCLES - 1);
         end
      end else begin : g_fixed
         assign last_c = DIV_W'(DIV_CYCLES - 1);
      end
   endgenerate

   assign step = (div_q == last_c) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cal_q <= '0;
      end else if (restart) begin
         div_q <= '0;
         cal_q <= '0;
      end else if (step) begin
         div_q <= '0;
         cal_q <= cal_end ? '0 : cal_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] sec_q,
   output logic             tick_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= step;
         if (load)      sec_q <= load_val;
         else if (step) sec_q <= sec_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] sec,
   input  logic [CNT_W-1:0] alarm_val,
   input  logic             alarm_en,
   input  logic             clr,
   output logic             wake_q
);
   logic hit;

   assign hit = tick && alarm_en && (sec == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wake_q <= 1'b0;
      else if (hit) wake_q <= 1'b1;
      else if (clr) wake_q <= 1'b0;
   end
endmodule

// File: rtl/rtc_trim.sv
module rtc_trim #(
   parameter int CNT_W       = 32,
   parameter int DIV_CYCLES  = 32768,
   parameter int TRIM_W      = 8,
   parameter int CAL_SECONDS = 60,
   parameter bit TRIM_EN     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sec_load,
   input  logic [CNT_W-1:0]         sec_load_val,
   input  logic signed [TRIM_W-1:0] trim_val,
   input  logic [CNT_W-1:0]         alarm_val,
   input  logic                     alarm_en,
   input  logic                     wake_clr,
   output logic [CNT_W-1:0]         sec_cnt,
   output logic                     sec_tick,
   output logic                     wake
);
   localparam int TRIM_MAX = 2 ** (TRIM_W - 1);

   generate
      if (DIV_CYCLES <= TRIM_MAX + 1) begin : g_bad_div
         $error("rtc_trim: DIV_CYCLES must exceed the largest trim by two");
      end
      if (CAL_SECONDS < 2) begin : g_bad_cal
         $error("rtc_trim: CAL_SECONDS must be at least 2");
      end
      if (CNT_W < 2 || TRIM_W < 2) begin : g_bad_w
         $error("rtc_trim: counter and trim widths must be at least 2");
      end
   endgenerate

   logic step;

   rtc_prescaler #(
      .DIV_CYCLES (DIV_CYCLES),
      .TRIM_W     (TRIM_W),
      .CAL_SECONDS(CAL_SECONDS),
      .TRIM_EN    (TRIM_EN)
   ) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(sec_load),
      .trim   (trim_val),
      .step   (step)
   );

   rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sec_load),
      .load_val(sec_load_val),
      .step    (step),
      .sec_q   (sec_cnt),
      .tick_q  (sec_tick)
   );

   rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sec_tick),
      .sec      (sec_cnt),
      .alarm_val(alarm_val),
      .alarm_en (alarm_en),
      .clr      (wake_clr),
      .wake_q   (wake)
   );
endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk #(
   parameter int CNT_W       = 32,
   parameter int DIV_CYCLES  = 32768,
   parameter int TRIM_W      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sec_load,
   input logic [CNT_W-1:0] sec_load_val,
   input logic [CNT_W-1:0] alarm_val,
   input logic             alarm_en,
   input logic             wake_clr,
   input logic [CNT_W-1:0] sec_cnt,
   input logic             sec_tick,
   input logic             wake
);
   localparam int TRIM_MAX = 2 ** (TRIM_W - 1);
   localparam int GAP_MIN  = DIV_CYCLES - (TRIM_MAX - 1);
   localparam int GAP_MAX  = DIV_CYCLES + TRIM_MAX;

   // Edges since the last tick or load; checks second length without deep $past.
   int unsigned gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap_q <= 0;
      else if (sec_load) gap_q <= 0;
      else if (sec_tick) gap_q <= 1;
      else if (gap_q < GAP_MAX + 2) gap_q <= gap_q + 1;
   end

   a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   a_r3_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> sec_cnt == CNT_W'($past(sec_cnt) + 1'b1));

   a_r3_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !$past(sec_load)) |-> $stable(sec_cnt));

   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      sec_load |=> (sec_cnt == $past(sec_load_val)) && !sec_tick);

   a_r4_period_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (gap_q >= GAP_MIN) && (gap_q <= GAP_MAX));

   a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> $past(sec_tick) && $past(alarm_en) && ($past(sec_cnt) == $past(alarm_val)));

   a_r7_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !wake_clr) |=> wake);

   a_r7_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_clr && !(sec_tick && alarm_en && sec_cnt == alarm_val)) |=> !wake);

   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_en && !wake) |=> !wake);
endmodule

bind rtc_trim rtc_trim_chk #(
   .CNT_W     (CNT_W),
   .DIV_CYCLES(DIV_CYCLES),
   .TRIM_W    (TRIM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_load    (sec_load),
   .sec_load_val(sec_load_val),
   .alarm_val   (alarm_val),
   .alarm_en    (alarm_en),
   .wake_clr    (wake_clr),
   .sec_cnt     (sec_cnt),
   .sec_tick    (sec_tick),
   .wake        (wake)
);

// File: tb/rtc_trim_tb.sv
module rtc_trim_tb;
   localparam int CNT_W = 32;
   localparam int DIV   = 200;
   localparam int CAL   = 4;
   localparam int TW    = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 sec_load = 1'b0;
   logic [CNT_W-1:0]     sec_load_val = '0;
   logic signed [TW-1:0] trim_val = '0;
   logic [CNT_W-1:0]     alarm_val = '0;
   logic                 alarm_en = 1'b0;
   logic                 wake_clr = 1'b0;
   logic [CNT_W-1:0]     sec_cnt;
   logic                 sec_tick;
   logic                 wake;

   always #2 clk = ~clk;

   rtc_trim #(.CNT_W(CNT_W), .DIV_CYCLES(DIV), .TRIM_W(TW), .CAL_SECONDS(CAL)) u_dut (
      .clk(clk), .rst_n(rst_n), .sec_load(sec_load), .sec_load_val(sec_load_val),
      .trim_val(trim_val), .alarm_val(alarm_val), .alarm_en(alarm_en),
      .wake_clr(wake_clr), .sec_cnt(sec_cnt), .sec_tick(sec_tick), .wake(wake));

   typedef struct { logic [CNT_W-1:0] sec; int gap; } exp_t;
   exp_t sb_q[$];

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver-side model state
   logic [CNT_W-1:0] m_sec = '0;
   int               m_cal = 0;
   int               m_trim = 0;

   task automatic push_seconds(input int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         m_sec = m_sec + 1'b1;
         e.sec = m_sec;
         e.gap = (m_cal == CAL - 1) ? DIV - m_trim : DIV;  // R4 calibrated second
         sb_q.push_back(e);
         m_cal = (m_cal + 1) % CAL;
      end
   endtask

   task automatic load(input logic [CNT_W-1:0] v);
      @(negedge clk);
      sec_load = 1'b1;
      sec_load_val = v;
      @(negedge clk);
      sec_load = 1'b0;
      chk("R2 load value", sec_cnt, v);
      chk("R2 no tick on load", sec_tick, 1'b0);
      m_sec = v;
      m_cal = 0;
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: edges since load/tick, compared against queued expectations
   logic ld_seen = 1'b0;
   always @(posedge clk) ld_seen <= sec_load;

   int  gap_cnt = 0;
   logic wake_at_tick = 1'b0;
   logic wake_next = 1'b0;
   bit  pend = 1'b0;

   always @(negedge clk) begin
      if (!rst_n || ld_seen) begin
         gap_cnt = 0;
      end else begin
         gap_cnt++;
         if (pend) begin
            wake_next = wake;
            pend = 1'b0;
         end
         if (sec_tick) begin
            wake_at_tick = wake;
            pend = 1'b1;
            if (sb_q.size() != 0) begin
               exp_t e;
               e = sb_q.pop_front();
               chk("R3/R5 seconds value", sec_cnt, e.sec);
               chk("R3/R4 second length", gap_cnt, e.gap);
            end
            gap_cnt = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset sec_cnt", sec_cnt, 0);
      chk("R1 reset sec_tick", sec_tick, 0);
      chk("R1 reset wake", wake, 0);
      rst_n = 1'b1;

      // R2 R3 R4: positive trim shortens every 4th second
      m_trim = 50; trim_val = 8'sd50;
      load(32'd100);
      push_seconds(9);
      drain();

      // R4: negative trim lengthens it
      m_trim = -60; trim_val = -8'sd60;
      load(32'd5000);
      push_seconds(5);
      drain();

      // R5: wrap through all ones
      m_trim = 0; trim_val = '0;
      load(32'hFFFF_FFFE);
      push_seconds(3);
      drain();

      // R6: alarm reached while enabled
      alarm_val = 32'd20; alarm_en = 1'b1;
      load(32'd18);
      push_seconds(2);
      drain();
      chk("R6 wake low on the tick", wake_at_tick, 1'b0);
      chk("R6 wake high one cycle later", wake_next, 1'b1);

      // R7: sticky across further ticks, then cleared
      push_seconds(2);
      drain();
      chk("R7 wake held", wake_next, 1'b1);
      @(negedge clk); wake_clr = 1'b1;
      @(negedge clk); wake_clr = 1'b0;
      chk("R7 wake cleared", wake, 1'b0);

      // R8: masked alarm
      alarm_en = 1'b0; alarm_val = 32'd24;
      push_seconds(2);
      drain();
      chk("R8 masked on tick", wake_at_tick, 1'b0);
      chk("R8 masked after tick", wake_next, 1'b0);
      chk("R8 masked wake", wake, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule